// File: doc/BRIEF.md
# Dual-Input Long-Press Reset Generator

This block turns a deliberate two-button hold into a single system reset. Two active-low button lines are each brought into the clock domain through a two-stage synchroniser. A qualify timer runs only while both lines are low at the same time. When the hold lasts for the selected timeout, the block issues one active-low reset pulse. If either button is let go early, the count is discarded. A new attempt needs both buttons low again and starts from zero.

All timing is counted in ticks from a prescaler, one tick every `CLK_PER_TICK` clocks. With the default settings a tick is 0.1 ms at 50 MHz. The timeout is a whole number of half-second units of `HALF_TICKS` ticks, chosen by a 3-bit select. The pulse width is fixed when the block is built: a short variant of about 2.2 ms or a long variant of about 70 ms.

The output is given two ways. `rst_req_no` is a plain active-low request. `pad_oe_o` is the pull-down enable for an open-drain pad, which floats whenever the pulse is not active, so that other reset sources can share the wire.

Top module: `press_reset_gen`

## Requirements
- R1: While `rst_ni` is low and just after it rises, `pad_oe_o` is 0 and `rst_req_no` is 1.
- R2: If both buttons are already low when reset is released, no pulse is produced until at least one button has been seen high.
- R3: The qualify timer starts when the later of the two buttons falls, in either order. The pulse begins after the selected timeout. `tsel_i` encodes the timeout in half-second units: 0→1, 1→2, 2→3, 3→4, 4→5, 5→6, 6→8, 7→10.
- R4: If either button rises before the timeout ends, the timer clears with no pulse. The next joint-low period is timed from its own start.
- R5: Each joint-low period gives at most one pulse. Holding both buttons low after a pulse gives no further pulse.
- R6: After a pulse, the block re-arms once at least one button goes high. It then fires again when both are next held low for the timeout.
- R7: The pulse lasts `SHORT_TICKS` ticks when `LONG_PULSE` is 0, and `LONG_TICKS` ticks when it is 1, within one tick.
- R8: `pad_oe_o` is 1 exactly when `rst_req_no` is 0, and the pad floats otherwise.
- R9: `tsel_i` is captured when the timer starts. Changing it during a count does not alter the running timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| btn_a_ni | input | 1 | First button, active low, asynchronous |
| btn_b_ni | input | 1 | Second button, active low, asynchronous |
| tsel_i | input | 3 | Timeout select, in half-second units (see R3) |
| rst_req_no | output | 1 | Active-low reset request |
| pad_oe_o | output | 1 | Open-drain pull-down enable, 1 during the pulse |

## Verification
The bench builds the block with `CLK_PER_TICK`=4, `HALF_TICKS`=5 and `LONG_PULSE`=1 with `LONG_TICKS`=6. These values bring the longest timeout down to 200 clocks and the pulse to about 24 clocks. At this scale every timeout code, an early release followed by a restart, a select change during a count and a long hold after a pulse all fit in a short run. Each expected pulse is given a start window and a width window, counted from the cycle in which the later button fell, so tick-phase uncertainty is allowed for. A pulse that comes late, too long or with nothing expected is reported.

// File: rtl/prg_pkg.sv
package prg_pkg;
  // timeout in half-second units for each select code
  function automatic int unsigned halves(logic [2:0] sel);
    case (sel)
      3'd6:    halves = 8;
      3'd7:    halves = 10;
      default: halves = 32'(sel) + 1;
    endcase
  endfunction
endpackage

// File: rtl/prg_sync.sv
module prg_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic s1_q, s2_q;
    // reset to 0 (pressed): a line must be seen high before arming
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/prg_prescaler.sv
module prg_prescaler #(
  parameter int unsigned DIV = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
      tick_o <= 1'b0;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < DIV);
endmodule

// File: rtl/prg_qualify.sv
module prg_qualify #(
  parameter int unsigned HALF_TICKS = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       both_low_i,
  input  logic [2:0] tsel_i,
  output logic       fire_o
);
  localparam int unsigned MAX_TICKS = 10 * HALF_TICKS;
  localparam int unsigned LW = $clog2(MAX_TICKS + 1);

  logic          armed_q, run_q;
  logic [LW-1:0] cnt_q, limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
      limit_q <= '0;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (!both_low_i) begin
        armed_q <= 1'b1;
        run_q   <= 1'b0;
        cnt_q   <= '0;
      end else if (armed_q && !run_q) begin
        run_q   <= 1'b1;
        cnt_q   <= '0;
        limit_q <= LW'(prg_pkg::halves(tsel_i) * HALF_TICKS);
      end else if (run_q && tick_i) begin
        if (cnt_q == limit_q - LW'(1)) begin
          fire_o  <= 1'b1;
          run_q   <= 1'b0;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + LW'(1);
        end
      end
    end
  end

  assert_fire_both_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(both_low_i));
  assert_clear_on_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !both_low_i |=> (!run_q && cnt_q == '0));
  assert_single_fire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
  assert_fire_needs_arm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fire_o) |-> $past(armed_q));
  assert_limit_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> $stable(limit_q));
endmodule

// File: rtl/prg_pulse.sv
module prg_pulse #(
  parameter int unsigned PULSE_TICKS = 22
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fire_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(PULSE_TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (fire_i) begin
      active_o <= 1'b1;
      cnt_q    <= '0;
    end else if (active_o && tick_i) begin
      if (cnt_q == CW'(PULSE_TICKS - 1)) active_o <= 1'b0;
      else                                cnt_q    <= cnt_q + CW'(1);
    end
  end

  assert_pulse_from_fire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(fire_i));
  assert_pulse_ends_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(tick_i));
endmodule

// File: rtl/press_reset_gen.sv
module press_reset_gen #(
  parameter int unsigned CLK_PER_TICK = 5000,
  parameter int unsigned HALF_TICKS   = 5000,
  parameter int unsigned SHORT_TICKS  = 22,
  parameter int unsigned LONG_TICKS   = 700,
  parameter bit          LONG_PULSE   = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       btn_a_ni,
  input  logic       btn_b_ni,
  input  logic [2:0] tsel_i,
  output logic       rst_req_no,
  output logic       pad_oe_o
);
  localparam int unsigned PULSE_TICKS = LONG_PULSE ? LONG_TICKS : SHORT_TICKS;

  logic [1:0] btn_s;
  logic       tick, fire, active;

  prg_sync #(.WIDTH(2)) i_sync (
    .clk_i, .rst_ni, .d_i({btn_b_ni, btn_a_ni}), .q_o(btn_s)
  );

  prg_prescaler #(.DIV(CLK_PER_TICK)) i_presc (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  prg_qualify #(.HALF_TICKS(HALF_TICKS)) i_qual (
    .clk_i, .rst_ni, .tick_i(tick), .both_low_i(btn_s == 2'b00),
    .tsel_i, .fire_o(fire)
  );

  prg_pulse #(.PULSE_TICKS(PULSE_TICKS)) i_pulse (
    .clk_i, .rst_ni, .tick_i(tick), .fire_i(fire), .active_o(active)
  );

  assign pad_oe_o   = active;
  assign rst_req_no = ~active;

  assert_idle_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !pad_oe_o);
  assert_pulse_needs_press_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pad_oe_o) |-> $past(btn_s == 2'b00, 2));
endmodule

// File: tb/test_press_reset_gen.sv
module test_press_reset_gen;
  localparam int CLK_PERIOD = 10;
  localparam int D    = 4;
  localparam int HALF = 5;
  localparam int W    = 6;

  typedef struct {
    int    lo;
    int    hi;
    int    wmin;
    int    wmax;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn_a = 1'b0, btn_b = 1'b0;
  logic [2:0] tsel = 3'd0;
  logic       rst_req_n, pad_oe;

  int   cyc = 0, checks = 0, fails = 0, seen = 0, r8_bad = 0;
  exp_t sb[$];

  press_reset_gen #(
    .CLK_PER_TICK(D), .HALF_TICKS(HALF), .SHORT_TICKS(3),
    .LONG_TICKS(W), .LONG_PULSE(1'b1)
  ) i_press_reset_gen (
    .clk_i(clk), .rst_ni(rst_n), .btn_a_ni(btn_a), .btn_b_ni(btn_b),
    .tsel_i(tsel), .rst_req_no(rst_req_n), .pad_oe_o(pad_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int halves_of(int sel);
    int t[8] = '{1, 2, 3, 4, 5, 6, 8, 10};
    return t[sel];
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // c: cycle in which the later button was driven low
  task automatic push_exp(int c, int sel, string tag);
    exp_t e;
    int   l = halves_of(sel) * HALF;
    e.lo = c + 3 + (l - 1) * D;
    e.hi = c + 6 + l * D;
    e.wmin = (W - 1) * D;
    e.wmax = W * D + 1;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor
  logic prev_oe = 1'b0;
  int   start_c = 0;
  exp_t cur;
  bit   have_cur = 1'b0;
  always @(negedge clk) begin
    if (pad_oe === rst_req_n) r8_bad++;
    if (pad_oe && !prev_oe) begin
      seen++;
      start_c = cyc;
      if (sb.size() == 0) begin
        chk(1'b0, "R5", "unexpected pulse at cycle", cyc, -1);
        have_cur = 1'b0;
      end else begin
        cur = sb.pop_front();
        have_cur = 1'b1;
        chk(cyc >= cur.lo && cyc <= cur.hi, cur.tag, "pulse start", cyc, cur.lo);
      end
    end
    if (!pad_oe && prev_oe && have_cur) begin
      chk((cyc - start_c) >= cur.wmin && (cyc - start_c) <= cur.wmax,
          "R7", "pulse width", cyc - start_c, W * D);
      have_cur = 1'b0;
    end
    prev_oe = pad_oe;
  end

  initial begin
    wait_cyc(4);
    chk(pad_oe == 1'b0 && rst_req_n == 1'b1, "R1", "idle in reset", pad_oe, 0);
    rst_n = 1'b1;
    wait_cyc(1);
    chk(pad_oe == 1'b0, "R1", "idle after reset", pad_oe, 0);
    wait_cyc(400);
    chk(seen == 0, "R2", "pulses with buttons low from reset", seen, 0);

    // R3: a falls last, shortest timeout
    btn_a = 1'b1; wait_cyc(5);
    tsel = 3'd0; btn_a = 1'b0; push_exp(cyc, 0, "R3");
    wait_cyc(400);
    chk(seen == 1, "R5", "pulses after long hold", seen, 1);

    // R6: re-arm, b falls first then a, select 3
    btn_a = 1'b1; btn_b = 1'b1; wait_cyc(5);
    tsel = 3'd3; btn_b = 1'b0; wait_cyc(20);
    btn_a = 1'b0; push_exp(cyc, 3, "R6");
    wait_cyc(300);
    chk(seen == 2, "R6", "pulse count after re-arm", seen, 2);

    // R4: early release then restart
    btn_a = 1'b1; wait_cyc(5);
    tsel = 3'd2; btn_a = 1'b0; wait_cyc(30);
    btn_a = 1'b1; wait_cyc(3);
    btn_a = 1'b0; push_exp(cyc, 2, "R4");
    wait_cyc(250);
    chk(seen == 3, "R4", "pulse count after restart", seen, 3);

    // R9: select changed mid count
    btn_b = 1'b1; wait_cyc(5);
    tsel = 3'd1; btn_b = 1'b0; push_exp(cyc, 1, "R9");
    wait_cyc(10);
    tsel = 3'd7;
    wait_cyc(300);
    chk(seen == 4, "R9", "pulse count with select change", seen, 4);

    // R3: longest timeout
    btn_b = 1'b1; wait_cyc(5);
    btn_b = 1'b0; push_exp(cyc, 7, "R3");
    wait_cyc(300);
    chk(seen == 5, "R3", "pulse count at longest timeout", seen, 5);

    chk(sb.size() == 0, "R3", "expected pulses not seen", sb.size(), 0);
    chk(r8_bad == 0, "R8", "pad enable vs request mismatches", r8_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule